// File: doc/BRIEF.md
# USB Endpoint Ping-Pong Bank Controller

This block keeps the bookkeeping for one non-control USB endpoint that is backed by two data banks used alternately. The USB engine reports simplified events: a packet has been stored, a bank has been transmitted, a SETUP arrived, or a NAK was returned to a host IN request. Firmware sees the endpoint through three small registers: interrupt flags, interrupt enables and read-only status. Firmware reads them with a read strobe and writes them with a write strobe. Packet storage, CRC, line signalling and address decoding are outside this block.

The handover of each bank hinges on one control bit, the bank-held bit. When it reads 1, firmware holds the current bank. On an OUT endpoint that bank holds a received packet. On an IN endpoint it is an empty bank ready to be filled. Firmware writes 0 to the bit to give the bank back. On OUT this frees the bank for new data. On IN it commits the data for sending. In both directions the release also advances the current-bank pointer to the other bank. The engine is told which bank to use next and whether it may use it. On OUT, a packet that arrives while firmware holds both banks must be NAKed by the engine, and the block ignores its store strobe.

Top module: `usbep_dual_bank`

## Requirements
- R1: During and after reset, every flag, enable, the bank-held bit, the direction flag and both bank pointers are 0. `irq` and `cpu_rdata` are 0. All three registers (address 0 flags, 1 enables, 2 status) read 0x00 in OUT mode.
- R2: OUT mode (`cfg_dir_in`=0): an accepted store with `usb_rx_setup`=0 into the current bank sets the bank-held bit (flags bit 0) and the received-data flag (flags bit 2) on the same edge.
- R3: Writing address 0 with bit 0 = 0 while the bank-held bit is 1 releases the current bank and toggles the current-bank pointer. The bank-held bit then shows whether firmware holds the new current bank. The pointer changes on no other occasion.
- R4: OUT mode: when firmware holds both banks, `usb_bank_avail` is 0 and a store strobe is ignored. It changes no flag, no pointer and no bank.
- R5: IN mode: a bank that holds no data and is not held by firmware passes to firmware on the next edge. When that bank is the current one, the bank-held bit and the transmit-ready flag (flags bit 1) are set on the same edge. Right after reset this happens on the first edge.
- R6: IN mode: a release commits the current bank. `usb_bank_avail` rises with `usb_bank_sel` naming the oldest committed bank. `usb_bank_sent` frees that bank and advances `usb_bank_sel`.
- R7: Writing 1 to any bit of the flags register has no effect. A flag is cleared only by writing 0 to its bit. A flag that is set by an event in the same cycle as it is cleared stays set.
- R8: Status register: bits 1:0 hold the current bank (00 = bank 0, 01 = bank 1), bit 2 holds the data-stage direction, and bits 7:3 read 0. Writes to it have no effect.
- R9: An accepted store with `usb_rx_setup`=1 sets the SETUP flag (flags bit 3) instead of the received-data flag. It also loads the direction bit from `usb_setup_dir_in` (1 = IN). The direction bit changes at no other time.
- R10: `usb_nak_in` sets the NAK flag (flags bit 4). It raises `irq` only while its enable bit is set.
- R11: `irq` is a register. It is high in exactly the cycles in which some flag and its enable (same bit position in register 1) are both 1.
- R12: The enable register stores bits 4:1. Its other bits read 0.
- R13: Events for the other direction are ignored. A store does nothing in IN mode, and `usb_bank_sent` does nothing in OUT mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dir_in | input | 1 | Endpoint direction, 1 = IN, held static between resets |
| usb_rx_stored | input | 1 | Engine has written a received packet into the selected bank |
| usb_rx_setup | input | 1 | Qualifies the store as a SETUP packet |
| usb_setup_dir_in | input | 1 | Direction of the data stage that follows the SETUP |
| usb_bank_sent | input | 1 | Engine has sent the selected bank and had it acknowledged |
| usb_nak_in | input | 1 | Engine has answered a host IN request with NAK |
| usb_bank_sel | output | 1 | Bank the engine must use next |
| usb_bank_avail | output | 1 | Engine may use the selected bank |
| cpu_addr | input | 2 | Register address: 0 flags, 1 enables, 2 status |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe; data appears on the next edge |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| irq | output | 1 | Endpoint interrupt |

## Verification
On every cycle the assertions check the bank pointer rules. The current bank moves only on a release of a held bank, and then always moves. A store refused for lack of a bank leaves the engine's bank selection alone. The bank-held bit rises in OUT mode only after a store. The direction bit and the NAK flag follow their events. The bench scenarios show the whole ownership round trip for each direction. They also cover register read-back of every field, the write-one immunity of flags, the enable gating of `irq`, and the events that are ignored in the wrong direction. These need sequences of writes and reads that no single-cycle property captures.

// File: rtl/usbep_pkg.sv
package usbep_pkg;

    localparam int NUM_BANKS   = 2;
    localparam int BANK_IDX_W  = $clog2(NUM_BANKS);
    localparam int CUR_FIELD_W = 2;
    localparam int NUM_FLAGS   = 4;

    localparam int ADDR_W      = 2;
    localparam int REG_W       = 8;

    localparam logic [ADDR_W-1:0] ADDR_FLAGS  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_ENABLE = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd2;

    localparam int HELD_BIT   = 0;
    localparam int FLAG_LSB   = 1;
    localparam int CUR_LSB    = 0;
    localparam int DIR_BIT    = CUR_LSB + CUR_FIELD_W;

    typedef struct packed {
        logic nak_in;
        logic rx_setup;
        logic rx_data;
        logic tx_ready;
    } ep_flags_t;

    typedef struct packed {
        logic [NUM_BANKS-1:0]  fw_own;
        logic [NUM_BANKS-1:0]  loaded;
        logic [BANK_IDX_W-1:0] cur;
        logic [BANK_IDX_W-1:0] hw;
        logic                  held;
    } bank_state_t;

    typedef struct packed {
        ep_flags_t             flags;
        logic [NUM_FLAGS-1:0]  en;
        logic                  dir;
        logic                  irq;
    } flag_state_t;

endpackage

// File: rtl/usbep_bank_ctrl.sv
module usbep_bank_ctrl
    import usbep_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  dir_in,
    input  logic                  rx_stored,
    input  logic                  bank_sent,
    input  logic                  rel_req,
    output logic [BANK_IDX_W-1:0] cur_bank,
    output logic [BANK_IDX_W-1:0] hw_bank,
    output logic                  hw_avail,
    output logic                  held,
    output logic                  rx_accept,
    output logic                  tx_event
);

    bank_state_t st_d, st_q;
    logic        fw_rel;
    logic        tx_done;

    always_comb begin
        st_d      = st_q;
        rx_accept = !dir_in && rx_stored && !st_q.fw_own[st_q.hw];
        tx_done   = dir_in && bank_sent && st_q.loaded[st_q.hw];
        fw_rel    = rel_req && st_q.held;

        // engine side: fill (OUT) or drain (IN) the selected bank
        if (rx_accept) begin
            st_d.fw_own[st_q.hw] = 1'b1;
            st_d.hw              = st_q.hw + 1'b1;
        end
        if (tx_done) begin
            st_d.loaded[st_q.hw] = 1'b0;
            st_d.hw              = st_q.hw + 1'b1;
        end

        // firmware side: give the current bank back and advance
        if (fw_rel) begin
            st_d.fw_own[st_q.cur] = 1'b0;
            st_d.loaded[st_q.cur] = dir_in;
            st_d.cur              = st_q.cur + 1'b1;
        end

        // IN: an empty bank owned by hardware is handed to firmware
        if (dir_in) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (!st_q.fw_own[b] && !st_q.loaded[b]) begin
                    st_d.fw_own[b] = 1'b1;
                end
            end
        end

        st_d.held = st_d.fw_own[st_d.cur];
        tx_event  = dir_in && st_d.held && (!st_q.held || fw_rel);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_bank = st_q.cur;
    assign hw_bank  = st_q.hw;
    assign held     = st_q.held;
    assign hw_avail = dir_in ? st_q.loaded[st_q.hw] : !st_q.fw_own[st_q.hw];

endmodule

// File: rtl/usbep_flags.sv
module usbep_flags
    import usbep_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_accept,
    input  logic                 rx_setup,
    input  logic                 setup_dir,
    input  logic                 tx_event,
    input  logic                 nak_in,
    input  logic                 flag_wr,
    input  logic [NUM_FLAGS-1:0] flag_wdata,
    input  logic                 en_wr,
    input  logic [NUM_FLAGS-1:0] en_wdata,
    output ep_flags_t            flags,
    output logic [NUM_FLAGS-1:0] en,
    output logic                 ctrl_dir,
    output logic                 irq
);

    flag_state_t          fs_d, fs_q;
    logic [NUM_FLAGS-1:0] set_v;
    logic [NUM_FLAGS-1:0] clr_v;

    always_comb begin
        fs_d  = fs_q;
        set_v = {nak_in, rx_accept && rx_setup, rx_accept && !rx_setup, tx_event};
        clr_v = flag_wr ? ~flag_wdata : '0;

        // an event in the same cycle outranks a clear
        fs_d.flags = ep_flags_t'(set_v | (fs_q.flags & ~clr_v));

        if (en_wr) begin
            fs_d.en = en_wdata;
        end
        if (rx_accept && rx_setup) begin
            fs_d.dir = setup_dir;
        end

        fs_d.irq = |(fs_d.flags & fs_d.en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q <= '0;
        end else begin
            fs_q <= fs_d;
        end
    end

    assign flags    = fs_q.flags;
    assign en       = fs_q.en;
    assign ctrl_dir = fs_q.dir;
    assign irq      = fs_q.irq;

endmodule

// File: rtl/usbep_regif.sv
module usbep_regif
    import usbep_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic                  cpu_wr,
    input  logic                  cpu_rd,
    input  logic [REG_W-1:0]      cpu_wdata,
    input  logic                  held,
    input  ep_flags_t             flags,
    input  logic [NUM_FLAGS-1:0]  en,
    input  logic                  ctrl_dir,
    input  logic [BANK_IDX_W-1:0] cur_bank,
    output logic                  flag_wr,
    output logic                  en_wr,
    output logic                  rel_req,
    output logic [NUM_FLAGS-1:0]  flag_wdata,
    output logic [NUM_FLAGS-1:0]  en_wdata,
    output logic [REG_W-1:0]      cpu_rdata
);

    logic [REG_W-1:0] rdata_d, rdata_q;
    logic [REG_W-1:0] rd_mux;

    always_comb begin
        flag_wr    = cpu_wr && (cpu_addr == ADDR_FLAGS);
        en_wr      = cpu_wr && (cpu_addr == ADDR_ENABLE);
        rel_req    = flag_wr && !cpu_wdata[HELD_BIT];
        flag_wdata = cpu_wdata[FLAG_LSB +: NUM_FLAGS];
        en_wdata   = cpu_wdata[FLAG_LSB +: NUM_FLAGS];

        rd_mux = '0;
        case (cpu_addr)
            ADDR_FLAGS: begin
                rd_mux[HELD_BIT]                = held;
                rd_mux[FLAG_LSB +: NUM_FLAGS]   = flags;
            end
            ADDR_ENABLE: begin
                rd_mux[FLAG_LSB +: NUM_FLAGS]   = en;
            end
            ADDR_STATUS: begin
                rd_mux[CUR_LSB +: CUR_FIELD_W]  = CUR_FIELD_W'(cur_bank);
                rd_mux[DIR_BIT]                 = ctrl_dir;
            end
            default: rd_mux = '0;
        endcase

        rdata_d = cpu_rd ? rd_mux : rdata_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign cpu_rdata = rdata_q;

endmodule

// File: rtl/usbep_dual_bank.sv
module usbep_dual_bank
    import usbep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_dir_in,
    input  logic              usb_rx_stored,
    input  logic              usb_rx_setup,
    input  logic              usb_setup_dir_in,
    input  logic              usb_bank_sent,
    input  logic              usb_nak_in,
    output logic              usb_bank_sel,
    output logic              usb_bank_avail,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [REG_W-1:0]  cpu_wdata,
    output logic [REG_W-1:0]  cpu_rdata,
    output logic              irq
);

    logic [BANK_IDX_W-1:0] cur_bank_w;
    logic [BANK_IDX_W-1:0] hw_bank_w;
    logic                  held_w;
    logic                  rx_accept_w;
    logic                  tx_event_w;
    logic                  rel_req_w;
    logic                  flag_wr_w;
    logic                  en_wr_w;
    logic [NUM_FLAGS-1:0]  flag_wdata_w;
    logic [NUM_FLAGS-1:0]  en_wdata_w;
    ep_flags_t             flags_w;
    logic [NUM_FLAGS-1:0]  en_w;
    logic                  ctrl_dir_w;

    usbep_bank_ctrl u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir_in    (cfg_dir_in),
        .rx_stored (usb_rx_stored),
        .bank_sent (usb_bank_sent),
        .rel_req   (rel_req_w),
        .cur_bank  (cur_bank_w),
        .hw_bank   (hw_bank_w),
        .hw_avail  (usb_bank_avail),
        .held      (held_w),
        .rx_accept (rx_accept_w),
        .tx_event  (tx_event_w)
    );

    usbep_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_accept  (rx_accept_w),
        .rx_setup   (usb_rx_setup),
        .setup_dir  (usb_setup_dir_in),
        .tx_event   (tx_event_w),
        .nak_in     (usb_nak_in),
        .flag_wr    (flag_wr_w),
        .flag_wdata (flag_wdata_w),
        .en_wr      (en_wr_w),
        .en_wdata   (en_wdata_w),
        .flags      (flags_w),
        .en         (en_w),
        .ctrl_dir   (ctrl_dir_w),
        .irq        (irq)
    );

    usbep_regif u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_addr   (cpu_addr),
        .cpu_wr     (cpu_wr),
        .cpu_rd     (cpu_rd),
        .cpu_wdata  (cpu_wdata),
        .held       (held_w),
        .flags      (flags_w),
        .en         (en_w),
        .ctrl_dir   (ctrl_dir_w),
        .cur_bank   (cur_bank_w),
        .flag_wr    (flag_wr_w),
        .en_wr      (en_wr_w),
        .rel_req    (rel_req_w),
        .flag_wdata (flag_wdata_w),
        .en_wdata   (en_wdata_w),
        .cpu_rdata  (cpu_rdata)
    );

    assign usb_bank_sel = hw_bank_w[0];

endmodule

// File: rtl/usbep_dual_bank_chk.sv
module usbep_dual_bank_chk
    import usbep_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_dir_in,
    input logic                  usb_rx_stored,
    input logic                  usb_rx_setup,
    input logic                  usb_nak_in,
    input logic                  usb_bank_sel,
    input logic                  usb_bank_avail,
    input logic [ADDR_W-1:0]     cpu_addr,
    input logic                  cpu_wr,
    input logic [REG_W-1:0]      cpu_wdata,
    input logic                  held,
    input logic [BANK_IDX_W-1:0] cur_bank,
    input logic                  ctrl_dir,
    input logic                  nak_flag
);

    logic rel_write;
    assign rel_write = cpu_wr && (cpu_addr == ADDR_FLAGS) && !cpu_wdata[HELD_BIT];

    // R2: in OUT mode the bank-held bit only rises after a store
    p_held_rise_after_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_dir_in && $rose(held)) |-> $past(usb_rx_stored));

    // R3: releasing a held bank always moves the pointer
    p_release_moves_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_write && held) |=> (cur_bank != $past(cur_bank)));

    // R3: without a release write the pointer stays put
    p_bank_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rel_write |=> $stable(cur_bank));

    // R4: a refused store leaves the engine's bank selection alone
    p_refused_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_dir_in && !usb_bank_avail && usb_rx_stored) |=> $stable(usb_bank_sel));

    // R9: direction bit changes only on a SETUP store
    p_dir_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(usb_rx_stored && usb_rx_setup) |=> $stable(ctrl_dir));

    // R10: a NAK event always leaves the NAK flag set
    p_nak_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        usb_nak_in |=> nak_flag);

endmodule

bind usbep_dual_bank usbep_dual_bank_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_dir_in     (cfg_dir_in),
    .usb_rx_stored  (usb_rx_stored),
    .usb_rx_setup   (usb_rx_setup),
    .usb_nak_in     (usb_nak_in),
    .usb_bank_sel   (usb_bank_sel),
    .usb_bank_avail (usb_bank_avail),
    .cpu_addr       (cpu_addr),
    .cpu_wr         (cpu_wr),
    .cpu_wdata      (cpu_wdata),
    .held           (held_w),
    .cur_bank       (cur_bank_w),
    .ctrl_dir       (ctrl_dir_w),
    .nak_flag       (flags_w.nak_in)
);

// File: tb/usbep_dual_bank_bench.sv
`timescale 1ns/1ps
module usbep_dual_bank_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_dir_in = 1'b0;
    logic       usb_rx_stored = 1'b0;
    logic       usb_rx_setup = 1'b0;
    logic       usb_setup_dir_in = 1'b0;
    logic       usb_bank_sent = 1'b0;
    logic       usb_nak_in = 1'b0;
    logic       usb_bank_sel;
    logic       usb_bank_avail;
    logic [1:0] cpu_addr = 2'd0;
    logic       cpu_wr = 1'b0;
    logic       cpu_rd = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       irq;

    always #2.5 clk = ~clk;

    usbep_dual_bank u_usbep_dual_bank (
        .clk              (clk),
        .rst_n            (rst_n),
        .cfg_dir_in       (cfg_dir_in),
        .usb_rx_stored    (usb_rx_stored),
        .usb_rx_setup     (usb_rx_setup),
        .usb_setup_dir_in (usb_setup_dir_in),
        .usb_bank_sent    (usb_bank_sent),
        .usb_nak_in       (usb_nak_in),
        .usb_bank_sel     (usb_bank_sel),
        .usb_bank_avail   (usb_bank_avail),
        .cpu_addr         (cpu_addr),
        .cpu_wr           (cpu_wr),
        .cpu_rd           (cpu_rd),
        .cpu_wdata        (cpu_wdata),
        .cpu_rdata        (cpu_rdata),
        .irq              (irq)
    );

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } rd_item_t;

    rd_item_t exp_q[$];
    int       n_chk  = 0;
    int       n_fail = 0;
    int       cycles = 0;
    bit       done   = 0;
    logic     rd_seen = 1'b0;

    // monitor: a read issued at one edge is compared at the following negedge
    always @(posedge clk) rd_seen <= cpu_rd && rst_n;

    always @(negedge clk) begin
        if (rd_seen) begin
            rd_item_t it;
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard: read data %h with no expected item", cpu_rdata);
            end else begin
                it = exp_q.pop_front();
                if (cpu_rdata !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: got %h expected %h", it.tag, cpu_rdata, it.exp);
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        rd_item_t it;
        @(negedge clk);
        cpu_addr = a;
        cpu_rd   = 1'b1;
        it.exp   = exp;
        it.tag   = tag;
        exp_q.push_back(it);
        @(negedge clk);
        cpu_rd   = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr  = a;
        cpu_wdata = d;
        cpu_wr    = 1'b1;
        @(negedge clk);
        cpu_wr    = 1'b0;
    endtask

    task automatic usb_store(input logic setup, input logic dir);
        @(negedge clk);
        usb_rx_stored    = 1'b1;
        usb_rx_setup     = setup;
        usb_setup_dir_in = dir;
        @(negedge clk);
        usb_rx_stored    = 1'b0;
        usb_rx_setup     = 1'b0;
    endtask

    task automatic usb_sent();
        @(negedge clk);
        usb_bank_sent = 1'b1;
        @(negedge clk);
        usb_bank_sent = 1'b0;
    endtask

    task automatic usb_nak();
        @(negedge clk);
        usb_nak_in = 1'b1;
        @(negedge clk);
        usb_nak_in = 1'b0;
    endtask

    task automatic do_reset(input logic dir);
        @(negedge clk);
        rst_n      = 1'b0;
        cfg_dir_in = dir;
        repeat (3) @(negedge clk);
        chk({7'd0, irq}, 8'h00, "R1 irq in reset");
        chk(cpu_rdata, 8'h00, "R1 rdata in reset");
        rst_n = 1'b1;
    endtask

    initial begin
        // ---------------- OUT endpoint ----------------
        do_reset(1'b0);
        rd(2'd0, 8'h00, "R1 flags after reset");
        rd(2'd1, 8'h00, "R1 enables after reset");
        rd(2'd2, 8'h00, "R1 status after reset");
        chk({7'd0, usb_bank_sel}, 8'h00, "R1 engine bank after reset");
        chk({7'd0, usb_bank_avail}, 8'h01, "R1 OUT bank free after reset");

        wr(2'd1, 8'hFF);
        rd(2'd1, 8'h1E, "R12 enable readback");

        usb_store(1'b0, 1'b0);
        rd(2'd0, 8'h05, "R2 held and data flag after store");
        chk({7'd0, irq}, 8'h01, "R11 irq on enabled data flag");

        wr(2'd0, 8'hFF);
        rd(2'd0, 8'h05, "R7 write ones changes nothing");

        usb_store(1'b0, 1'b0);
        chk({7'd0, usb_bank_avail}, 8'h00, "R4 no free bank when both held");
        usb_store(1'b0, 1'b0);
        chk({7'd0, usb_bank_sel}, 8'h00, "R4 refused store keeps selection");
        rd(2'd2, 8'h00, "R4 refused store keeps current bank");

        wr(2'd0, 8'hFB);
        rd(2'd0, 8'h01, "R7 data flag cleared by writing 0");
        chk({7'd0, irq}, 8'h00, "R11 irq drops with flag");

        wr(2'd0, 8'hFE);
        rd(2'd0, 8'h01, "R3 next bank still held");
        rd(2'd2, 8'h01, "R3 current bank is 1");
        chk({7'd0, usb_bank_avail}, 8'h01, "R3 released bank free for engine");

        wr(2'd0, 8'hFE);
        rd(2'd0, 8'h00, "R3 no bank held after second release");
        rd(2'd2, 8'h00, "R3 current bank back to 0");

        usb_store(1'b1, 1'b1);
        rd(2'd0, 8'h09, "R9 SETUP flag and held bit");
        rd(2'd2, 8'h04, "R9 direction IN recorded");

        wr(2'd2, 8'hFF);
        rd(2'd2, 8'h04, "R8 status write ignored");

        usb_sent();
        rd(2'd0, 8'h09, "R13 bank_sent ignored in OUT");
        chk({7'd0, usb_bank_sel}, 8'h01, "R13 selection unchanged by bank_sent");

        wr(2'd1, 8'h00);
        chk({7'd0, irq}, 8'h00, "R11 irq off with enables cleared");
        usb_nak();
        rd(2'd0, 8'h19, "R10 NAK flag set");
        chk({7'd0, irq}, 8'h00, "R10 NAK masked");
        wr(2'd1, 8'h10);
        chk({7'd0, irq}, 8'h01, "R10 NAK raises irq when enabled");
        wr(2'd0, 8'hEF);
        rd(2'd0, 8'h09, "R7 NAK flag cleared by writing 0");
        chk({7'd0, irq}, 8'h00, "R11 irq off after clear");

        // ---------------- IN endpoint ----------------
        do_reset(1'b1);
        rd(2'd0, 8'h03, "R5 free bank handed over with tx ready");
        chk({7'd0, usb_bank_avail}, 8'h00, "R5 nothing to send yet");

        wr(2'd0, 8'hFD);
        rd(2'd0, 8'h01, "R7 tx ready cleared, bank still held");

        wr(2'd0, 8'hFE);
        rd(2'd0, 8'h03, "R6 commit moves to free bank with tx ready");
        rd(2'd2, 8'h01, "R6 current bank is 1");
        chk({7'd0, usb_bank_avail}, 8'h01, "R6 committed bank offered");
        chk({7'd0, usb_bank_sel}, 8'h00, "R6 engine sends bank 0 first");

        wr(2'd0, 8'hFD);
        wr(2'd0, 8'hFE);
        rd(2'd0, 8'h00, "R6 both banks committed");
        rd(2'd2, 8'h00, "R6 current bank back to 0");

        usb_store(1'b0, 1'b0);
        rd(2'd0, 8'h00, "R13 store ignored in IN");
        chk({7'd0, usb_bank_sel}, 8'h00, "R13 selection unchanged by store");

        usb_sent();
        @(negedge clk);
        rd(2'd0, 8'h03, "R5 sent bank returns with tx ready");
        chk({7'd0, usb_bank_sel}, 8'h01, "R6 engine moves to bank 1");
        chk({7'd0, usb_bank_avail}, 8'h01, "R6 bank 1 still queued");

        repeat (2) @(negedge clk);
        chk(exp_q.size(), 8'd0, "scoreboard drained");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule